// File: doc/BRIEF.md
# Port-Output Instruction Issuer

This block sits in an execution pipeline and turns one of four single-byte port-output opcodes into a single write request in I/O space. It forms the 16-bit port address either from an 8-bit immediate or from the DX register value. It picks the access width from the opcode, or from the operand-size attribute for the wide forms. It places the accumulator value on the low data lanes and sets the matching byte enables.

A request goes through a fixed sequence. The block rejects a LOCK prefix. It asks a separate privilege block for permission and issues the write with a valid/ready handshake. It then holds the next instruction until an external write-buffer-empty input is sampled high.

The controller has seven states:
- `ST_IDLE` accepts an instruction.
- `ST_CHECK` waits for the privilege answer.
- `ST_ISSUE` presents the write.
- `ST_DRAIN` waits for write-buffer-empty.
- `ST_DONE`, `ST_UD` and `ST_GP` each last one cycle and report completion, invalid-opcode and privilege fault respectively.

The transitions are:
- IDLE→UD when an accepted known opcode has LOCK.
- IDLE→CHECK when it has no LOCK.
- CHECK→ISSUE on grant.
- CHECK→GP on denial.
- ISSUE→DRAIN on `io_ready`.
- DRAIN→DONE on `wbuf_empty`.
- DONE, UD and GP return to IDLE.

An unknown opcode keeps the controller in IDLE.

Top module: `port_out_issuer`

## Requirements
- R1: Opcodes 0xE6 and 0xE7 (immediate forms) drive `io_addr` = {8'h00, `imm`}, so the port range is 0 to 255.
- R2: Opcodes 0xEE and 0xEF (register forms) drive `io_addr` = `dx_val`, covering the full 0 to 65535 range.
- R3: Opcodes 0xE6 and 0xEE issue a byte write: `io_size`=0, `io_be`=4'b0001, `io_data`={24'h0, `acc_val[7:0]`}.
- R4: Opcodes 0xE7 and 0xEF issue a 16-bit write when `opsize32`=0 (`io_size`=1, `io_be`=4'b0011, data = low 16 bits zero-extended), and a 32-bit write when `opsize32`=1 (`io_size`=2, `io_be`=4'b1111, data = `acc_val`).
- R5: A known opcode accepted with `lock_pfx`=1 pulses `fault_ud` for one cycle the next cycle, and raises neither `chk_req` nor `io_valid`.
- R6: When the privilege block answers with `chk_ok`=0, `fault_gp` pulses for one cycle and no write issues.
- R7: While `io_valid` is high and `io_ready` is low, `io_valid`, `io_addr`, `io_data`, `io_be` and `io_size` hold steady.
- R8: After the write handshake, `stall` stays high and `done` stays low until `wbuf_empty` is sampled high in the drain state. `done` pulses in the following cycle.
- R9: An opcode outside the four listed leaves the block idle: no request, no fault, `stall` low.
- R10: `ins_ready` is high exactly when the block is idle, `stall` is its inverse, and both hold these values after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction presented |
| ins_ready | output | 1 | Block idle and accepting |
| opcode | input | 8 | Opcode byte |
| imm | input | 8 | Immediate byte following the opcode |
| opsize32 | input | 1 | Operand-size attribute, 1 selects 32 bits for wide forms |
| lock_pfx | input | 1 | LOCK prefix present |
| dx_val | input | 16 | DX register value |
| acc_val | input | 32 | Accumulator value |
| chk_req | output | 1 | Permission request to the privilege block (port on io_addr) |
| chk_done | input | 1 | Privilege answer valid |
| chk_ok | input | 1 | Privilege answer: 1 grant, 0 fault |
| io_valid | output | 1 | Write request valid |
| io_ready | input | 1 | Bus accepts the write |
| io_addr | output | 16 | Port address |
| io_data | output | 32 | Write data, low lanes |
| io_be | output | 4 | Byte enables |
| io_size | output | 2 | 0 byte, 1 word, 2 doubleword |
| wbuf_empty | input | 1 | External write buffer empty |
| stall | output | 1 | Hold the next instruction |
| done | output | 1 | One-cycle completion pulse |
| fault_ud | output | 1 | One-cycle invalid-opcode fault pulse |
| fault_gp | output | 1 | One-cycle privilege fault pulse |

## Verification
The bound checker watches several properties on every cycle:
- the request holds steady while the bus stalls;
- byte enables agree with the reported size;
- the three end-of-instruction pulses are mutually exclusive;
- a LOCK fault never coincides with a request;
- `done` only follows a sampled write-buffer-empty;
- `ins_ready` never overlaps `stall`.

Some behaviour only the directed scenarios can show, because the checker has no record of which opcode was accepted:
- that the address comes from the immediate or from DX depending on the opcode;
- that the data lanes carry the right accumulator bytes;
- that an unknown opcode is silently dropped;
- that a denied request never reaches the bus.

// File: rtl/pout_pkg.sv
package pout_pkg;

    localparam logic [7:0] OPC_IMM_BYTE = 8'hE6;
    localparam logic [7:0] OPC_IMM_WIDE = 8'hE7;
    localparam logic [7:0] OPC_REG_BYTE = 8'hEE;
    localparam logic [7:0] OPC_REG_WIDE = 8'hEF;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } io_size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_DRAIN,
        ST_DONE,
        ST_UD,
        ST_GP
    } ctrl_state_e;

endpackage

// File: rtl/pout_decode.sv
module pout_decode
    import pout_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IMM_W  = 8
) (
    input  logic [7:0]        opcode,
    input  logic [IMM_W-1:0]  imm,
    input  logic [ADDR_W-1:0] dx_val,
    input  logic              opsize32,
    output logic              known,
    output logic [ADDR_W-1:0] port_addr,
    output io_size_e          size
);

    logic use_imm;
    logic narrow;

    always_comb begin
        known   = 1'b1;
        use_imm = 1'b0;
        narrow  = 1'b0;
        unique case (opcode)
            OPC_IMM_BYTE: begin use_imm = 1'b1; narrow = 1'b1; end
            OPC_IMM_WIDE: begin use_imm = 1'b1; narrow = 1'b0; end
            OPC_REG_BYTE: begin use_imm = 1'b0; narrow = 1'b1; end
            OPC_REG_WIDE: begin use_imm = 1'b0; narrow = 1'b0; end
            default:      known = 1'b0;
        endcase
    end

    // immediate form: zero-extended, upper address bits forced low
    assign port_addr = use_imm ? ADDR_W'(imm) : dx_val;

    always_comb begin
        if (narrow)        size = SZ_BYTE;
        else if (opsize32) size = SZ_DWORD;
        else               size = SZ_WORD;
    end

endmodule

// File: rtl/pout_lane.sv
module pout_lane
    import pout_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  io_size_e            size,
    input  logic [DATA_W-1:0]   acc,
    output logic [DATA_W/8-1:0] be,
    output logic [DATA_W-1:0]   data
);

    localparam int LANES = DATA_W / 8;

    int nbytes;

    always_comb begin
        unique case (size)
            SZ_BYTE:  nbytes = 1;
            SZ_WORD:  nbytes = 2;
            SZ_DWORD: nbytes = 4;
            default:  nbytes = 0;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g]           = (nbytes > g);
        assign data[8*g +: 8]  = be[g] ? acc[8*g +: 8] : 8'h00;
    end

endmodule

// File: rtl/pout_ctrl.sv
module pout_ctrl
    import pout_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ins_valid,
    input  logic known,
    input  logic lock_pfx,
    input  logic chk_done,
    input  logic chk_ok,
    input  logic io_ready,
    input  logic wbuf_empty,
    output logic ins_ready,
    output logic capture,
    output logic chk_req,
    output logic io_valid,
    output logic stall,
    output logic done,
    output logic fault_ud,
    output logic fault_gp
);

    ctrl_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ins_valid && known) state_nx = lock_pfx ? ST_UD : ST_CHECK;
            end
            ST_CHECK: begin
                if (chk_done) state_nx = chk_ok ? ST_ISSUE : ST_GP;
            end
            ST_ISSUE: begin
                if (io_ready) state_nx = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (wbuf_empty) state_nx = ST_DONE;
            end
            ST_DONE, ST_UD, ST_GP: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        ins_ready = 1'b0;
        chk_req   = 1'b0;
        io_valid  = 1'b0;
        done      = 1'b0;
        fault_ud  = 1'b0;
        fault_gp  = 1'b0;
        unique case (state)
            ST_IDLE:  ins_ready = 1'b1;
            ST_CHECK: chk_req   = 1'b1;
            ST_ISSUE: io_valid  = 1'b1;
            ST_DRAIN: ;
            ST_DONE:  done      = 1'b1;
            ST_UD:    fault_ud  = 1'b1;
            ST_GP:    fault_gp  = 1'b1;
            default:  ;
        endcase
        stall   = !ins_ready;
        capture = ins_ready && ins_valid && known;
    end

endmodule

// File: rtl/port_out_issuer.sv
module port_out_issuer
    import pout_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    output logic              ins_ready,
    input  logic [7:0]        opcode,
    input  logic [IMM_W-1:0]  imm,
    input  logic              opsize32,
    input  logic              lock_pfx,
    input  logic [ADDR_W-1:0] dx_val,
    input  logic [DATA_W-1:0] acc_val,
    output logic              chk_req,
    input  logic              chk_done,
    input  logic              chk_ok,
    output logic              io_valid,
    input  logic              io_ready,
    output logic [ADDR_W-1:0] io_addr,
    output logic [DATA_W-1:0] io_data,
    output logic [DATA_W/8-1:0] io_be,
    output logic [1:0]        io_size,
    input  logic              wbuf_empty,
    output logic              stall,
    output logic              done,
    output logic              fault_ud,
    output logic              fault_gp
);

    logic              dec_known;
    logic [ADDR_W-1:0] dec_addr;
    io_size_e          dec_size;
    logic              capture;

    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_acc;
    io_size_e          req_size;

    pout_decode #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_decode (
        .opcode    (opcode),
        .imm       (imm),
        .dx_val    (dx_val),
        .opsize32  (opsize32),
        .known     (dec_known),
        .port_addr (dec_addr),
        .size      (dec_size)
    );

    pout_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ins_valid  (ins_valid),
        .known      (dec_known),
        .lock_pfx   (lock_pfx),
        .chk_done   (chk_done),
        .chk_ok     (chk_ok),
        .io_ready   (io_ready),
        .wbuf_empty (wbuf_empty),
        .ins_ready  (ins_ready),
        .capture    (capture),
        .chk_req    (chk_req),
        .io_valid   (io_valid),
        .stall      (stall),
        .done       (done),
        .fault_ud   (fault_ud),
        .fault_gp   (fault_gp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr <= '0;
            req_acc  <= '0;
            req_size <= SZ_BYTE;
        end else if (capture) begin
            req_addr <= dec_addr;
            req_acc  <= acc_val;
            req_size <= dec_size;
        end
    end

    pout_lane #(.DATA_W(DATA_W)) u_lane (
        .size (req_size),
        .acc  (req_acc),
        .be   (io_be),
        .data (io_data)
    );

    assign io_addr = req_addr;
    assign io_size = req_size;

endmodule

// File: rtl/pout_checker.sv
module pout_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ins_ready,
    input logic                stall,
    input logic                chk_req,
    input logic                io_valid,
    input logic                io_ready,
    input logic [ADDR_W-1:0]   io_addr,
    input logic [DATA_W-1:0]   io_data,
    input logic [DATA_W/8-1:0] io_be,
    input logic [1:0]          io_size,
    input logic                wbuf_empty,
    input logic                done,
    input logic                fault_ud,
    input logic                fault_gp
);

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && !io_ready) |=> (io_valid && $stable(io_addr) && $stable(io_data)
                                     && $stable(io_be) && $stable(io_size)));

    // R3 / R4: enables agree with the encoded size
    assert_be_matches_size_R4: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid |-> ((io_size == 2'd0 && io_be == 4'b0001) ||
                      (io_size == 2'd1 && io_be == 4'b0011) ||
                      (io_size == 2'd2 && io_be == 4'b1111)));

    assert_lock_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_ud |-> (!io_valid && !chk_req));

    assert_gp_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault_gp |-> (!io_valid && !done && $past(chk_req)));

    assert_done_after_wbe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wbuf_empty));

    assert_stall_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_ready) |=> (stall && !done));

    assert_single_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault_ud, fault_gp}));

    assert_ready_vs_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ready != stall);

endmodule

bind port_out_issuer pout_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pout_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_ready  (ins_ready),
    .stall      (stall),
    .chk_req    (chk_req),
    .io_valid   (io_valid),
    .io_ready   (io_ready),
    .io_addr    (io_addr),
    .io_data    (io_data),
    .io_be      (io_be),
    .io_size    (io_size),
    .wbuf_empty (wbuf_empty),
    .done       (done),
    .fault_ud   (fault_ud),
    .fault_gp   (fault_gp)
);

// File: tb/test_port_out_issuer.sv
module test_port_out_issuer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic        ins_ready;
    logic [7:0]  opcode = 8'h00;
    logic [7:0]  imm = 8'h00;
    logic        opsize32 = 1'b0;
    logic        lock_pfx = 1'b0;
    logic [15:0] dx_val = 16'h0;
    logic [31:0] acc_val = 32'h0;
    logic        chk_req;
    logic        chk_done = 1'b0;
    logic        chk_ok = 1'b0;
    logic        io_valid;
    logic        io_ready = 1'b0;
    logic [15:0] io_addr;
    logic [31:0] io_data;
    logic [3:0]  io_be;
    logic [1:0]  io_size;
    logic        wbuf_empty = 1'b0;
    logic        stall;
    logic        done;
    logic        fault_ud;
    logic        fault_gp;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_out_issuer i_port_out_issuer (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .opcode(opcode), .imm(imm), .opsize32(opsize32), .lock_pfx(lock_pfx),
        .dx_val(dx_val), .acc_val(acc_val), .chk_req(chk_req), .chk_done(chk_done),
        .chk_ok(chk_ok), .io_valid(io_valid), .io_ready(io_ready), .io_addr(io_addr),
        .io_data(io_data), .io_be(io_be), .io_size(io_size), .wbuf_empty(wbuf_empty),
        .stall(stall), .done(done), .fault_ud(fault_ud), .fault_gp(fault_gp)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    // present one instruction for one cycle, then let the controller run
    task automatic present(input logic [7:0] op, input logic [7:0] im, input logic [15:0] dx,
                           input logic [31:0] acc, input logic sz32, input logic lk);
        opcode = op; imm = im; dx_val = dx; acc_val = acc; opsize32 = sz32; lock_pfx = lk;
        ins_valid = 1'b1;
        @(negedge clk);
        ins_valid = 1'b0;
        opcode = 8'h00; imm = 8'h00; dx_val = 16'h0; acc_val = 32'h0; lock_pfx = 1'b0;
    endtask

    // full granted write with bus and drain delays; expectations derived from R1..R4
    task automatic run_write(input logic [7:0] op, input logic [7:0] im, input logic [15:0] dx,
                             input logic [31:0] acc, input logic sz32,
                             input int io_dly, input int wb_dly);
        logic [15:0] e_addr;
        logic [1:0]  e_size;
        logic [3:0]  e_be;
        logic [31:0] e_data;
        bit          imm_form;
        bit          byte_form;
        imm_form  = (op == 8'hE6) || (op == 8'hE7);
        byte_form = (op == 8'hE6) || (op == 8'hEE);
        e_addr = imm_form ? {8'h00, im} : dx;
        if (byte_form)  begin e_size = 2'd0; e_be = 4'b0001; e_data = {24'h0, acc[7:0]}; end
        else if (sz32)  begin e_size = 2'd2; e_be = 4'b1111; e_data = acc; end
        else            begin e_size = 2'd1; e_be = 4'b0011; e_data = {16'h0, acc[15:0]}; end

        present(op, im, dx, acc, sz32, 1'b0);
        check("R10", "stall while busy", 32'(stall), 32'd1);
        check("R5", "chk_req for unlocked", 32'(chk_req), 32'd1);
        chk_done = 1'b1; chk_ok = 1'b1;
        @(negedge clk);
        chk_done = 1'b0;
        check("R7", "io_valid", 32'(io_valid), 32'd1);
        check(imm_form ? "R1" : "R2", "io_addr", 32'(io_addr), 32'(e_addr));
        check(byte_form ? "R3" : "R4", "io_size", 32'(io_size), 32'(e_size));
        check(byte_form ? "R3" : "R4", "io_be", 32'(io_be), 32'(e_be));
        check(byte_form ? "R3" : "R4", "io_data", io_data, e_data);
        for (int k = 0; k < io_dly; k++) begin
            @(negedge clk);
            check("R7", "valid held", 32'(io_valid), 32'd1);
            check("R7", "addr held", 32'(io_addr), 32'(e_addr));
            check("R7", "data held", io_data, e_data);
        end
        io_ready = 1'b1;
        @(negedge clk);
        io_ready = 1'b0;
        check("R8", "valid dropped after handshake", 32'(io_valid), 32'd0);
        check("R8", "stall in drain", 32'(stall), 32'd1);
        for (int k = 0; k < wb_dly; k++) begin
            check("R8", "no done before wbuf_empty", 32'(done), 32'd0);
            @(negedge clk);
        end
        check("R8", "still stalled", 32'(stall), 32'd1);
        wbuf_empty = 1'b1;
        @(negedge clk);
        wbuf_empty = 1'b0;
        check("R8", "done pulse", 32'(done), 32'd1);
        @(negedge clk);
        check("R8", "done one cycle", 32'(done), 32'd0);
        check("R10", "ready again", 32'(ins_ready), 32'd1);
    endtask

    task automatic run_locked(input logic [7:0] op);
        present(op, 8'h21, 16'h1234, 32'hDEADBEEF, 1'b1, 1'b1);
        check("R5", "fault_ud", 32'(fault_ud), 32'd1);
        check("R5", "no chk_req", 32'(chk_req), 32'd0);
        check("R5", "no io_valid", 32'(io_valid), 32'd0);
        @(negedge clk);
        check("R5", "fault_ud one cycle", 32'(fault_ud), 32'd0);
        check("R5", "back to idle", 32'(ins_ready), 32'd1);
    endtask

    task automatic run_denied(input logic [7:0] op);
        present(op, 8'h80, 16'hBEEF, 32'h11223344, 1'b0, 1'b0);
        check("R6", "chk_req", 32'(chk_req), 32'd1);
        chk_done = 1'b1; chk_ok = 1'b0;
        @(negedge clk);
        chk_done = 1'b0;
        check("R6", "fault_gp", 32'(fault_gp), 32'd1);
        check("R6", "no io_valid", 32'(io_valid), 32'd0);
        @(negedge clk);
        check("R6", "fault_gp one cycle", 32'(fault_gp), 32'd0);
        check("R6", "no io_valid after", 32'(io_valid), 32'd0);
        check("R6", "idle after fault", 32'(ins_ready), 32'd1);
    endtask

    task automatic run_unknown(input logic [7:0] op, input logic lk);
        present(op, 8'h10, 16'h0010, 32'hCAFEF00D, 1'b1, lk);
        for (int k = 0; k < 3; k++) begin
            check("R9", "ins_ready", 32'(ins_ready), 32'd1);
            check("R9", "stall", 32'(stall), 32'd0);
            check("R9", "chk_req", 32'(chk_req), 32'd0);
            check("R9", "fault_ud", 32'(fault_ud), 32'd0);
            check("R9", "io_valid", 32'(io_valid), 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10", "ins_ready after reset", 32'(ins_ready), 32'd1);
        check("R10", "stall after reset", 32'(stall), 32'd0);
        check("R10", "io_valid after reset", 32'(io_valid), 32'd0);

        run_write(8'hE6, 8'hFF, 16'hABCD, 32'h12345678, 1'b1, 0, 0);   // R1 R3
        run_write(8'hEE, 8'h55, 16'hFFFF, 32'hA5A5A5C3, 1'b0, 2, 1);   // R2 R3
        run_write(8'hE7, 8'h00, 16'h9999, 32'h87654321, 1'b0, 1, 3);   // R1 R4 word
        run_write(8'hE7, 8'h7F, 16'h0000, 32'hF00DCAFE, 1'b1, 0, 2);   // R1 R4 dword
        run_write(8'hEF, 8'h33, 16'h8001, 32'h0BADBEEF, 1'b1, 3, 0);   // R2 R4 dword
        run_write(8'hEF, 8'h44, 16'h0100, 32'hFFFF1234, 1'b0, 0, 4);   // R2 R4 word
        run_locked(8'hE6);
        run_locked(8'hEF);
        run_denied(8'hEE);
        run_denied(8'hE7);
        run_unknown(8'hEC, 1'b0);
        run_unknown(8'hE5, 1'b1);
        run_write(8'hEE, 8'h00, 16'h0000, 32'h000000FF, 1'b0, 0, 0);   // R2 R3 low edge
        finish_run();
    end

endmodule